// File: doc/BRIEF.md
# Lockable set-associative cache controller

The controller fronts a backing memory with a set-associative store of whole lines. Line size, set count and way count are parameters, and each must be a power of two. A requester issues one command at a time through a valid/ready port. Loads come back on a return port as a full line tagged with the request number. Stores merge selected bytes and are write-allocate. Misses reach memory through a single line-wide read/write channel that finishes each transfer with an acknowledge.

Every way holds a tag, a valid bit, a dirty bit, a lock bit and a recency rank. A preload can pin a line so that replacement never takes it, and an unlock command releases it. If every way of a set is pinned, loads and stores to that set pass straight through to memory and nothing is allocated. Lines can be dropped one at a time or all together. The write-back variant of this command first saves dirty data to memory.

Top module: `lcache_ctrl`

## Requirements
- R1: An address splits into the line offset (low log2(LINE_BYTES) bits), the set index (next log2(SETS) bits) and the tag (remaining high bits). `mem_addr_o` carries the line address, which is the address shifted right by the offset width.
- R2: A load (op code 0) that hits returns the stored line on `ret_data_o`, with `ret_id_o` equal to the request number, during a one-cycle `ret_valid_o` pulse and with no memory access. A load that misses reads the line once from memory and returns it in the same way.
- R3: A store (op code 1) replaces the bytes whose `req_be_i` bit is set (byte b is data bits 8b+7:8b) and marks the line dirty. A store that misses first reads the line (write-allocate). Neither case writes memory.
- R4: When the chosen victim is valid and dirty, its line is written to memory at its own line address before the new line is read.
- R5: The victim on a miss is the unlocked way with the lowest recency rank. A locked way is never chosen.
- R6: Ranks reset to the way index. A hit or a fill gives the touched way rank WAYS-1, and every way ranked above its old rank drops by one.
- R7: A preload (op code 4) allocates a missing line and sets its lock when `req_lock_i` is 1. A preload that hits sets the lock when `req_lock_i` is 1. An unlock (op code 5) that hits clears the lock.
- R8: When every way of the addressed set is locked, a load reads memory and returns the data, and a store writes memory with `mem_be_o` equal to `req_be_i`. Neither allocates, so a repeat access misses again. A preload in that case does nothing.
- R9: Invalidate (op code 2) clears the valid, dirty and lock bits of the hit line and writes nothing back. Flush (op code 3) does the same but first writes the line to memory if it is dirty. With `req_all_i` set, either command applies to every line in the cache.
- R10: A request whose number is all ones is ignored. It causes no state change, no memory access and no return.
- R11: A request is taken only while `req_ready_o` is 1. Ready stays low from acceptance until the command completes. A memory request holds its address until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Command present |
| req_ready_o | output | 1 | Controller idle, command taken |
| req_op_i | input | 3 | Command code (see R2, R3, R7, R9) |
| req_addr_i | input | ADDR_W | Byte address |
| req_id_i | input | ID_W | Request number, all ones = none |
| req_wdata_i | input | 8*LINE_BYTES | Store data, line aligned |
| req_be_i | input | LINE_BYTES | Store byte enables |
| req_lock_i | input | 1 | Preload locks the line |
| req_all_i | input | 1 | Invalidate/flush applies to whole cache |
| ret_valid_o | output | 1 | Load data valid pulse |
| ret_id_o | output | ID_W | Request number of returned load |
| ret_data_o | output | 8*LINE_BYTES | Returned line |
| mem_req_o | output | 1 | Memory transfer pending |
| mem_we_o | output | 1 | Transfer is a write |
| mem_addr_o | output | ADDR_W-log2(LINE_BYTES) | Line address |
| mem_wdata_o | output | 8*LINE_BYTES | Write data |
| mem_be_o | output | LINE_BYTES | Write byte enables |
| mem_ack_i | input | 1 | Transfer done, read data valid |
| mem_rdata_i | input | 8*LINE_BYTES | Read data |

## Verification
Most tag, dirty, lock or rank faults stay silent until a later command exposes them. A wrong rank or lock bit shows at the next miss in that set, where the wrong line is evicted or written back and the count of memory transfers changes. A lost dirty bit shows only when a flush or eviction skips a write and memory diverges. A behavioural model therefore tracks every line and compares the return data and the per-command read and write counts, and it ends with a full flush followed by a compare of the backing memory.

// File: rtl/lcache_pkg.sv
package lcache_pkg;
  typedef enum logic [2:0] {
    OP_LOAD    = 3'd0,
    OP_STORE   = 3'd1,
    OP_INVAL   = 3'd2,
    OP_FLUSH   = 3'd3,
    OP_PRELOAD = 3'd4,
    OP_UNLOCK  = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_WALK, ST_WB, ST_CLR, ST_FILL, ST_DIRECT
  } st_e;
endpackage

// File: rtl/lcache_hit.sv
module lcache_hit #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]           tag_cmp_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);
  always_comb begin
    hit_o = 1'b0;
    way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid_i[w] && tag_i[w] == tag_cmp_i) begin
        hit_o = 1'b1;
        way_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/lcache_victim.sv
module lcache_victim #(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][WAY_W-1:0] rank_i,
  input  logic [WAYS-1:0]            lock_i,
  output logic                       found_o,
  output logic [WAY_W-1:0]           way_o
);
  logic [WAY_W-1:0] best;

  always_comb begin
    found_o = 1'b0;
    way_o   = '0;
    best    = '1;
    for (int w = 0; w < WAYS; w++) begin
      if (!lock_i[w] && (!found_o || rank_i[w] < best)) begin
        found_o = 1'b1;
        way_o   = WAY_W'(w);
        best    = rank_i[w];
      end
    end
  end
endmodule

// File: rtl/lcache_lru.sv
module lcache_lru #(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][WAY_W-1:0] rank_i,
  input  logic [WAY_W-1:0]           touch_i,
  output logic [WAYS-1:0][WAY_W-1:0] rank_o
);
  logic [WAY_W-1:0] old_rank;

  always_comb begin
    old_rank = rank_i[touch_i];
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == touch_i)     rank_o[w] = WAY_W'(WAYS - 1);
      else if (rank_i[w] > old_rank) rank_o[w] = rank_i[w] - 1'b1;
      else                           rank_o[w] = rank_i[w];
    end
  end
endmodule

// File: rtl/lcache_ctrl.sv
module lcache_ctrl
  import lcache_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LINE_BYTES = 4,
  parameter int SETS       = 4,
  parameter int WAYS       = 4,
  parameter int ID_W       = 8,
  localparam int LINE_W    = 8 * LINE_BYTES,
  localparam int LA_W      = ADDR_W - $clog2(LINE_BYTES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [2:0]            req_op_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [ID_W-1:0]       req_id_i,
  input  logic [LINE_W-1:0]     req_wdata_i,
  input  logic [LINE_BYTES-1:0] req_be_i,
  input  logic                  req_lock_i,
  input  logic                  req_all_i,
  output logic                  ret_valid_o,
  output logic [ID_W-1:0]       ret_id_o,
  output logic [LINE_W-1:0]     ret_data_o,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [LA_W-1:0]       mem_addr_o,
  output logic [LINE_W-1:0]     mem_wdata_o,
  output logic [LINE_BYTES-1:0] mem_be_o,
  input  logic                  mem_ack_i,
  input  logic [LINE_W-1:0]     mem_rdata_i
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = LA_W - IDX_W;
  localparam logic [ID_W-1:0] NO_ID = '1;

  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][WAYS-1:0]             valid_q, dirty_q, lock_q;
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0]  rank_q;
  logic [SETS-1:0][WAYS-1:0][LINE_W-1:0] data_q;

  st_e                   state_q;
  op_e                   q_op;
  logic [LA_W-1:0]       q_line;
  logic [ID_W-1:0]       q_id;
  logic [LINE_W-1:0]     q_wdata;
  logic [LINE_BYTES-1:0] q_be;
  logic                  q_lock, q_all, q_alloc;
  logic [IDX_W-1:0]      cur_set;
  logic [WAY_W-1:0]      cur_way;
  logic                  ret_valid_q;
  logic [ID_W-1:0]       ret_id_q;
  logic [LINE_W-1:0]     ret_data_q;

  logic [IDX_W-1:0]      q_set;
  logic [TAG_W-1:0]      q_tag;
  logic                  hit, vic_found;
  logic [WAY_W-1:0]      hit_way, vic_way, touch_way;
  logic [WAYS-1:0][WAY_W-1:0] rank_nxt;
  logic                  unused_off;

  assign unused_off = ^req_addr_i[OFF_W-1:0];
  assign q_set      = q_line[IDX_W-1:0];
  assign q_tag      = q_line[LA_W-1 -: TAG_W];
  assign touch_way  = (state_q == ST_LOOK) ? hit_way : cur_way;

  lcache_hit #(.WAYS(WAYS), .TAG_W(TAG_W)) u_hit (
    .tag_i(tag_q[q_set]), .valid_i(valid_q[q_set]), .tag_cmp_i(q_tag),
    .hit_o(hit), .way_o(hit_way)
  );

  lcache_victim #(.WAYS(WAYS)) u_victim (
    .rank_i(rank_q[q_set]), .lock_i(lock_q[q_set]),
    .found_o(vic_found), .way_o(vic_way)
  );

  lcache_lru #(.WAYS(WAYS)) u_lru (
    .rank_i(rank_q[q_set]), .touch_i(touch_way), .rank_o(rank_nxt)
  );

  function automatic logic [LINE_W-1:0] merge_f(input logic [LINE_W-1:0] old_d,
                                                input logic [LINE_W-1:0] new_d,
                                                input logic [LINE_BYTES-1:0] be);
    logic [LINE_W-1:0] r;
    for (int b = 0; b < LINE_BYTES; b++)
      r[8*b +: 8] = be[b] ? new_d[8*b +: 8] : old_d[8*b +: 8];
    return r;
  endfunction

  // control and metadata
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      valid_q     <= '0;
      dirty_q     <= '0;
      lock_q      <= '0;
      tag_q       <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) rank_q[s][w] <= WAY_W'(w);
      q_op        <= OP_LOAD;
      q_line      <= '0;
      q_id        <= '0;
      q_wdata     <= '0;
      q_be        <= '0;
      q_lock      <= 1'b0;
      q_all       <= 1'b0;
      q_alloc     <= 1'b0;
      cur_set     <= '0;
      cur_way     <= '0;
      ret_valid_q <= 1'b0;
      ret_id_q    <= '0;
      ret_data_q  <= '0;
    end else begin
      ret_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i && req_id_i != NO_ID) begin
          q_op    <= op_e'(req_op_i);
          q_line  <= req_addr_i[ADDR_W-1:OFF_W];
          q_id    <= req_id_i;
          q_wdata <= req_wdata_i;
          q_be    <= req_be_i;
          q_lock  <= req_lock_i;
          q_all   <= req_all_i;
          state_q <= ST_LOOK;
        end
        ST_LOOK: begin
          state_q <= ST_IDLE;
          case (q_op)
            OP_LOAD, OP_STORE, OP_PRELOAD: begin
              if (hit) begin
                rank_q[q_set] <= rank_nxt;
                if (q_op == OP_LOAD) begin
                  ret_valid_q <= 1'b1;
                  ret_id_q    <= q_id;
                  ret_data_q  <= data_q[q_set][hit_way];
                end
                if (q_op == OP_STORE) dirty_q[q_set][hit_way] <= 1'b1;
                if (q_op == OP_PRELOAD && q_lock) lock_q[q_set][hit_way] <= 1'b1;
              end else if (vic_found) begin
                cur_set <= q_set;
                cur_way <= vic_way;
                q_alloc <= 1'b1;
                state_q <= (valid_q[q_set][vic_way] && dirty_q[q_set][vic_way])
                           ? ST_WB : ST_FILL;
              end else if (q_op != OP_PRELOAD) begin
                state_q <= ST_DIRECT;
              end
            end
            OP_UNLOCK: if (hit) lock_q[q_set][hit_way] <= 1'b0;
            OP_INVAL, OP_FLUSH: begin
              q_alloc <= 1'b0;
              if (q_all) begin
                cur_set <= '0;
                cur_way <= '0;
                state_q <= ST_WALK;
              end else if (hit) begin
                cur_set <= q_set;
                cur_way <= hit_way;
                state_q <= ST_WALK;
              end
            end
            default: ;
          endcase
        end
        ST_WALK: state_q <= (q_op == OP_FLUSH && valid_q[cur_set][cur_way] &&
                             dirty_q[cur_set][cur_way]) ? ST_WB : ST_CLR;
        ST_WB: if (mem_ack_i) begin
          dirty_q[cur_set][cur_way] <= 1'b0;
          state_q <= q_alloc ? ST_FILL : ST_CLR;
        end
        ST_CLR: begin
          valid_q[cur_set][cur_way] <= 1'b0;
          dirty_q[cur_set][cur_way] <= 1'b0;
          lock_q[cur_set][cur_way]  <= 1'b0;
          if (q_all && !(&{cur_set, cur_way})) begin
            {cur_set, cur_way} <= {cur_set, cur_way} + 1'b1;
            state_q <= ST_WALK;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_FILL: if (mem_ack_i) begin
          tag_q[q_set][cur_way]   <= q_tag;
          valid_q[q_set][cur_way] <= 1'b1;
          dirty_q[q_set][cur_way] <= (q_op == OP_STORE);
          lock_q[q_set][cur_way]  <= (q_op == OP_PRELOAD) && q_lock;
          rank_q[q_set]           <= rank_nxt;
          if (q_op == OP_LOAD) begin
            ret_valid_q <= 1'b1;
            ret_id_q    <= q_id;
            ret_data_q  <= mem_rdata_i;
          end
          state_q <= ST_IDLE;
        end
        ST_DIRECT: if (mem_ack_i) begin
          if (q_op == OP_LOAD) begin
            ret_valid_q <= 1'b1;
            ret_id_q    <= q_id;
            ret_data_q  <= mem_rdata_i;
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // line storage, no reset
  always_ff @(posedge clk_i) begin
    if (state_q == ST_LOOK && q_op == OP_STORE && hit)
      data_q[q_set][hit_way] <= merge_f(data_q[q_set][hit_way], q_wdata, q_be);
    else if (state_q == ST_FILL && mem_ack_i)
      data_q[q_set][cur_way] <= (q_op == OP_STORE) ? merge_f(mem_rdata_i, q_wdata, q_be)
                                                   : mem_rdata_i;
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign ret_valid_o = ret_valid_q;
  assign ret_id_o    = ret_id_q;
  assign ret_data_o  = ret_data_q;
  assign mem_req_o   = (state_q == ST_WB) || (state_q == ST_FILL) || (state_q == ST_DIRECT);
  assign mem_we_o    = (state_q == ST_WB) || (state_q == ST_DIRECT && q_op == OP_STORE);
  assign mem_addr_o  = (state_q == ST_WB) ? {tag_q[cur_set][cur_way], cur_set} : q_line;
  assign mem_wdata_o = (state_q == ST_WB) ? data_q[cur_set][cur_way] : q_wdata;
  assign mem_be_o    = (state_q == ST_DIRECT && q_op == OP_STORE) ? q_be : '1;

  // rank permutation monitor
  logic rank_perm_ok;
  logic [WAYS-1:0] seen;
  always_comb begin
    rank_perm_ok = 1'b1;
    seen = '0;
    for (int s = 0; s < SETS; s++) begin
      seen = '0;
      for (int w = 0; w < WAYS; w++) seen[rank_q[s][w]] = 1'b1;
      if (seen != '1) rank_perm_ok = 1'b0;
    end
  end

  p_rank_perm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rank_perm_ok);
  p_victim_unlocked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOOK && !hit && vic_found) |-> !lock_q[q_set][vic_way]);
  p_ret_id_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o |-> ret_id_o != NO_ID);
  p_busy_mem_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);
  p_mem_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
  p_wb_then_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WB && mem_ack_i && q_alloc) |=> (mem_req_o && !mem_we_o));
endmodule

// File: tb/lcache_ctrl_tb.sv
`timescale 1ns/1ps
module lcache_ctrl_tb;
  localparam int NS = 4, NW = 4;
  localparam int LD = 0, ST = 1, INV = 2, FL = 3, PL = 4, UL = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic        req_valid_i = 0, req_lock_i = 0, req_all_i = 0, mem_ack_i = 0;
  logic [2:0]  req_op_i = 0;
  logic [11:0] req_addr_i = 0;
  logic [7:0]  req_id_i = 0;
  logic [31:0] req_wdata_i = 0, mem_rdata_i = 0;
  logic [3:0]  req_be_i = 0;
  logic        req_ready_o, ret_valid_o, mem_req_o, mem_we_o;
  logic [7:0]  ret_id_o;
  logic [31:0] ret_data_o, mem_wdata_o;
  logic [9:0]  mem_addr_o;
  logic [3:0]  mem_be_o;

  lcache_ctrl #(.ADDR_W(12), .LINE_BYTES(4), .SETS(NS), .WAYS(NW), .ID_W(8)) u_dut (.*);

  int tests = 0, fails = 0;
  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] init_line(int line);
    return (32'(line) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic [31:0] mg(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  // backing memory
  logic [31:0] mem [int];
  int rd_cnt = 0, wr_cnt = 0, seq = 0, rd_seq = 0, wr_seq = 0, lat = 0;
  int last_rd_addr = 0, last_wr_addr = 0;
  logic [3:0] last_be = 0;
  function automatic logic [31:0] mem_rd(int l);
    return mem.exists(l) ? mem[l] : init_line(l);
  endfunction
  initial forever begin
    @(negedge clk_i);
    if (mem_ack_i) mem_ack_i = 1'b0;
    else if (mem_req_o) begin
      if (lat == 1) begin
        lat = 0;
        seq++;
        if (mem_we_o) begin
          mem[int'(mem_addr_o)] = mg(mem_rd(int'(mem_addr_o)), mem_wdata_o, mem_be_o);
          wr_cnt++; wr_seq = seq; last_wr_addr = int'(mem_addr_o); last_be = mem_be_o;
        end else begin
          mem_rdata_i = mem_rd(int'(mem_addr_o));
          rd_cnt++; rd_seq = seq; last_rd_addr = int'(mem_addr_o);
        end
        mem_ack_i = 1'b1;
      end else lat++;
    end
  end

  // reference model
  int m_tag [NS][NW], m_r [NS][NW];
  bit m_v [NS][NW], m_d [NS][NW], m_l [NS][NW];
  logic [31:0] m_data [NS][NW];
  logic [31:0] ref_mem [int];
  function automatic logic [31:0] ref_rd(int l);
    return ref_mem.exists(l) ? ref_mem[l] : init_line(l);
  endfunction
  function automatic int m_hit(int s, int t);
    for (int w = 0; w < NW; w++) if (m_v[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction
  function automatic int m_victim(int s);
    int best = -1;
    for (int w = 0; w < NW; w++)
      if (!m_l[s][w] && (best < 0 || m_r[s][w] < m_r[s][best])) best = w;
    return best;
  endfunction
  function automatic void m_touch(int s, int w);
    int old = m_r[s][w];
    for (int x = 0; x < NW; x++) if (m_r[s][x] > old) m_r[s][x]--;
    m_r[s][w] = NW - 1;
  endfunction
  function automatic void m_drop(int s, int w, bit fl, inout int ewr);
    if (fl && m_v[s][w] && m_d[s][w]) begin
      ewr++; ref_mem[m_tag[s][w]*NS + s] = m_data[s][w];
    end
    m_v[s][w] = 0; m_d[s][w] = 0; m_l[s][w] = 0;
  endfunction

  bit exp_ret = 0, got_ret = 0;
  logic [31:0] got_data;
  logic [7:0]  got_id;
  initial forever begin
    @(negedge clk_i);
    if (ret_valid_o) begin
      got_ret = 1; got_data = ret_data_o; got_id = ret_id_o;
      if (!exp_ret) chk(0, "R2", "unexpected return", 1, 0);
    end
  end

  logic [7:0] next_id = 0;
  task automatic issue(int op, int t, int s, logic [31:0] wd, logic [3:0] be,
                       bit lk, bit all, bit none, string req);
    int erd = 0, ewr = 0, line = t * NS + s, h, v;
    logic [31:0] edata = 0;
    logic [7:0] id = none ? 8'hFF : next_id;
    bit eret = 0;
    if (!none) begin
      next_id++;
      case (op)
        LD, ST, PL: begin
          h = m_hit(s, t);
          if (h >= 0) begin
            m_touch(s, h);
            if (op == LD) begin eret = 1; edata = m_data[s][h]; end
            if (op == ST) begin m_data[s][h] = mg(m_data[s][h], wd, be); m_d[s][h] = 1; end
            if (op == PL && lk) m_l[s][h] = 1;
          end else begin
            v = m_victim(s);
            if (v >= 0) begin
              if (m_v[s][v] && m_d[s][v]) begin
                ewr++; ref_mem[m_tag[s][v]*NS + s] = m_data[s][v];
              end
              erd++;
              m_data[s][v] = ref_rd(line); m_tag[s][v] = t;
              m_v[s][v] = 1; m_d[s][v] = 0; m_l[s][v] = (op == PL) && lk;
              if (op == ST) begin m_data[s][v] = mg(m_data[s][v], wd, be); m_d[s][v] = 1; end
              m_touch(s, v);
              if (op == LD) begin eret = 1; edata = m_data[s][v]; end
            end else if (op == LD) begin
              erd++; eret = 1; edata = ref_rd(line);
            end else if (op == ST) begin
              ewr++; ref_mem[line] = mg(ref_rd(line), wd, be);
            end
          end
        end
        UL: begin h = m_hit(s, t); if (h >= 0) m_l[s][h] = 0; end
        default: begin
          if (all) begin
            for (int ss = 0; ss < NS; ss++)
              for (int w = 0; w < NW; w++) m_drop(ss, w, op == FL, ewr);
          end else begin
            h = m_hit(s, t);
            if (h >= 0) m_drop(s, h, op == FL, ewr);
          end
        end
      endcase
    end
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    exp_ret = eret; got_ret = 0;
    begin
      int rd0 = rd_cnt, wr0 = wr_cnt;
      req_valid_i = 1; req_op_i = 3'(op); req_addr_i = 12'((t << 4) | (s << 2) | (t & 3));
      req_id_i = id; req_wdata_i = wd; req_be_i = be; req_lock_i = lk; req_all_i = all;
      @(negedge clk_i);
      req_valid_i = 0;
      if (!none) chk(!req_ready_o, "R11", {req, " ready low while busy"}, req_ready_o, 0);
      while (!req_ready_o) @(negedge clk_i);
      @(negedge clk_i);
      chk(got_ret == eret, req, "return present", got_ret, eret);
      if (eret) begin
        chk(got_data == edata, req, "return data", got_data, edata);
        chk(got_id == id, req, "return id", got_id, id);
      end
      chk(rd_cnt - rd0 == erd, req, "memory reads", rd_cnt - rd0, erd);
      chk(wr_cnt - wr0 == ewr, req, "memory writes", wr_cnt - wr0, ewr);
    end
    exp_ret = 0;
  endtask

  task automatic ld(int t, int s, string r); issue(LD, t, s, 0, 0, 0, 0, 0, r); endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    tests++; fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        m_r[s][w] = w; m_v[s][w] = 0; m_d[s][w] = 0; m_l[s][w] = 0; m_tag[s][w] = 0;
      end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(req_ready_o == 1, "R11", "reset ready", req_ready_o, 1);
    chk(ret_valid_o == 0, "R2", "reset return", ret_valid_o, 0);
    chk(mem_req_o == 0, "R11", "reset mem_req", mem_req_o, 0);

    ld(1, 0, "R2 load miss");
    chk(last_rd_addr == 1 * NS + 0, "R1", "line address", last_rd_addr, 4);
    ld(1, 0, "R2 load hit");
    issue(ST, 1, 0, 32'hCAFE_F00D, 4'b0101, 0, 0, 0, "R3 store hit");
    ld(1, 0, "R3 merged");
    issue(ST, 2, 0, 32'h1122_3344, 4'b1100, 0, 0, 0, "R3 store miss allocate");
    ld(2, 0, "R3 allocated");
    ld(3, 0, "R6 fill");
    ld(4, 0, "R6 fill");
    ld(2, 0, "R6 reorder hit");
    ld(5, 0, "R4 dirty eviction");
    chk(last_wr_addr == 1 * NS, "R4", "writeback address", last_wr_addr, 4);
    chk(wr_seq < rd_seq, "R4", "writeback before fill", wr_seq, rd_seq);
    ld(3, 0, "R5 hit");
    ld(6, 0, "R5 lowest rank victim");
    ld(1, 0, "R5 refetch");

    issue(ST, 5, 0, 32'hFFFF_FFFF, 4'hF, 0, 0, 1, "R10 ignored store");
    ld(5, 0, "R10 unchanged");

    for (int t = 7; t <= 10; t++) issue(PL, t, 1, 0, 0, 1, 0, 0, "R7 preload lock");
    ld(11, 1, "R8 direct load");
    ld(11, 1, "R8 no allocation");
    issue(ST, 11, 1, 32'hA1B2_C3D4, 4'b0011, 0, 0, 0, "R8 direct store");
    chk(last_be == 4'b0011, "R8", "direct byte enables", last_be, 4'b0011);
    ld(11, 1, "R8 direct data");
    ld(7, 1, "R7 locked line hit");
    issue(PL, 12, 1, 0, 0, 1, 0, 0, "R8 preload all locked");
    issue(UL, 8, 1, 0, 0, 0, 0, 0, "R7 unlock");
    ld(11, 1, "R7 allocate in unlocked way");
    ld(11, 1, "R7 hit after allocate");
    issue(PL, 11, 1, 0, 0, 1, 0, 0, "R7 lock on hit");
    ld(12, 1, "R8 relocked set");
    issue(PL, 13, 2, 0, 0, 0, 0, 0, "R7 preload no lock");
    ld(13, 2, "R7 preloaded hit");

    issue(ST, 11, 1, 32'h0BAD_0BAD, 4'hF, 0, 0, 0, "R9 dirty setup");
    issue(INV, 11, 1, 0, 0, 0, 0, 0, "R9 invalidate");
    ld(11, 1, "R9 refetch after invalidate");
    issue(ST, 3, 0, 32'h5566_7788, 4'b1001, 0, 0, 0, "R9 dirty setup");
    issue(FL, 3, 0, 0, 0, 0, 0, 0, "R9 flush line");
    issue(ST, 6, 0, 32'h1357_9BDF, 4'b0110, 0, 0, 0, "R9 dirty setup");
    issue(FL, 0, 0, 0, 0, 0, 1, 0, "R9 flush all");
    for (int t = 1; t <= 13; t++)
      for (int s = 0; s < 3; s++)
        chk(mem_rd(t * NS + s) == ref_rd(t * NS + s), "R9", "memory after flush",
            mem_rd(t * NS + s), ref_rd(t * NS + s));
    ld(7, 1, "R9 unlocked and empty");
    ld(6, 0, "R9 empty");
    issue(INV, 0, 0, 0, 0, 0, 1, 0, "R9 invalidate all");
    ld(6, 0, "R9 empty again");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule